// File: doc/BRIEF.md
# Locality Interrupt Enable and Status Unit

This unit keeps one interrupt-enable word and one interrupt-status word for each locality of a multi-locality command interface, and drives one interrupt line that all localities share. Event pulses come in from the locality arbiter and the command engine, each tagged with a target locality and a set of source bits. An event is latched into the target's status word only when the target's global enable and the enable for that source are both set. Latching any bit raises the line.

Software clears status bits by writing ones to them. Only the locality that currently owns the interface may change its own enable or status word. When such a clear leaves the writer's status at zero, the line drops, even if another locality still holds pending bits. The unit also returns a fixed capability word and a read-only vector number. Reads are combinational from the selected register.

Register select `reg_sel`: 0 selects the enable word, 1 the status word, 2 the vector number, 3 the capability word.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset, every locality's enable word reads 0x0000_0008, every status word reads 0, and `irq` is low.
- R2: The writable enable bits are bit 31 (global enable), bits 4:3 (polarity, stored only), bit 0 (data available), bit 1 (status valid), bit 2 (locality changed) and bit 7 (command ready). All other enable bits always read 0, so writing all ones reads back 0x8000_009F.
- R3: `evt_src` bit 0 maps to status bit 0, bit 1 to bit 1, bit 2 to bit 2 and bit 3 to bit 7. A source sets its status bit in the target locality on the next clock edge only if that locality's enable bit 31 and the source's enable bit are both set.
- R4: `irq` goes high on the clock edge at which any status bit is latched, and it rises at no other time.
- R5: Writing the status word clears each supported bit (mask 0x87) that is written as one. Bits written as zero are left unchanged. Status bits outside 0x87 are never set.
- R6: `irq` falls only on a status write by the active locality that leaves that locality's status at zero. This happens even if other localities still hold set bits. A partial clear leaves `irq` high.
- R7: Enable and status writes whose `reg_loc` differs from `active_loc` are ignored. They are also ignored when `active_loc` is NUM_LOC or above, which means no locality is active.
- R8: Select 2 reads the parameter VECTOR in bits 3:0 and ignores writes. Select 3 always reads 0x97.
- R9: Events whose `evt_loc` is NUM_LOC or above change no status word and do not touch `irq`.
- R10: A write changes only the bytes whose `reg_be` bit is set (bit k covers data bits 8k+7:8k). Both enable and status words follow this rule.
- R11: If a status write and an event hit the same locality in the same cycle, the event's bits stay set. A clear cannot hide a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_loc | input | LOC_W | Locality that owns the interface; NUM_LOC or above means none |
| reg_loc | input | LOC_W | Locality addressed by the register access |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 capability |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for the selected register |
| evt_vld | input | 1 | Event pulse |
| evt_loc | input | LOC_W | Target locality of the event |
| evt_src | input | 4 | Event sources: data avail, status valid, locality changed, command ready |
| irq | output | 1 | Shared interrupt line, active high |

## Verification
The assertions check on every cycle that an event for a locality with its global enable clear leaves that status word unchanged, and that no unsupported status bit is ever set. They also check that a foreign-locality write never alters an enable word, and that the line only rises after an accepted event and only falls after an owner's status write.

Some behaviours depend on exact data and sequence, and only the bench scenarios can show them:
- the source-to-bit mapping;
- byte-lane merging;
- the line dropping while another locality is still pending;
- event-over-clear priority in one cycle;
- the fixed reads.

// File: rtl/loc_irq_unit.sv
module loc_irq_unit #(
  parameter int         NUM_LOC = 5,
  parameter int         LOC_W   = 3,
  parameter logic [3:0] VECTOR  = 4'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             evt_vld,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_src,
  output logic             irq
);

  localparam logic [LOC_W:0] NL       = NUM_LOC[LOC_W:0];
  localparam logic [31:0]    EN_RST   = 32'h0000_0008;
  localparam logic [31:0]    SUP      = 32'h0000_0087;
  localparam logic [31:0]    EN_WMASK = 32'h8000_009F;
  localparam logic [31:0]    CAPS     = SUP | 32'h0000_0010;
  localparam logic [1:0]     SEL_EN   = 2'd0;
  localparam logic [1:0]     SEL_ST   = 2'd1;
  localparam logic [1:0]     SEL_VEC  = 2'd2;

  logic [31:0] en_q  [NUM_LOC];
  logic [31:0] st_q  [NUM_LOC];
  logic [31:0] en_nx [NUM_LOC];
  logic [31:0] st_nx [NUM_LOC];
  logic [NUM_LOC-1:0] set_any, drop;
  logic irq_q;

  wire act_ok = {1'b0, active_loc} < NL;
  wire loc_ok = {1'b0, reg_loc} < NL;
  wire owner  = act_ok && (reg_loc == active_loc);
  wire evt_ok = evt_vld && ({1'b0, evt_loc} < NL);

  wire [31:0] bmask   = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
  wire [31:0] ev_bits = {24'b0, evt_src[3], 4'b0, evt_src[2:0]};

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    wire hit   = owner && (reg_loc == LOC_W'(i));
    wire en_wr = reg_wr && (reg_sel == SEL_EN) && hit;
    wire st_wr = reg_wr && (reg_sel == SEL_ST) && hit;
    wire ev_hit = evt_ok && (evt_loc == LOC_W'(i));
    wire [31:0] set_i = (ev_hit && en_q[i][31]) ? (ev_bits & en_q[i]) : 32'b0;
    wire [31:0] clr_i = st_wr ? (reg_wdata & bmask & SUP) : 32'b0;

    assign en_nx[i]   = en_wr ? ((en_q[i] & ~bmask) | (reg_wdata & bmask & EN_WMASK)) : en_q[i];
    assign st_nx[i]   = (st_q[i] & ~clr_i) | set_i;
    assign set_any[i] = |set_i;
    assign drop[i]    = st_wr && (st_nx[i] == 32'b0);

    // R3
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hit && !en_q[i][31] && !st_wr) |=> $stable(st_q[i]));
    // R5
    sup_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] & ~SUP) == 32'b0);
    // R7
    foreign_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_loc == LOC_W'(i)) && !owner) |=> $stable(en_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOC; i++) begin
        en_q[i] <= EN_RST;
        st_q[i] <= 32'b0;
      end
      irq_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_LOC; i++) begin
        en_q[i] <= en_nx[i];
        st_q[i] <= st_nx[i];
      end
      if (|set_any)   irq_q <= 1'b1;
      else if (|drop) irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (reg_sel)
      SEL_EN:  reg_rdata = loc_ok ? en_q[reg_loc] : 32'b0;
      SEL_ST:  reg_rdata = loc_ok ? st_q[reg_loc] : 32'b0;
      SEL_VEC: reg_rdata = {28'b0, VECTOR};
      default: reg_rdata = CAPS;
    endcase
  end

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(evt_ok));
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(reg_wr && (reg_sel == SEL_ST) && owner));

endmodule

// File: tb/loc_irq_unit_bench.sv
module loc_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  active_loc = 3'd7, reg_loc = 3'd0, evt_loc = 3'd0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0, evt_vld = 1'b0;
  logic [3:0]  reg_be = 4'h0, evt_src = 4'h0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] en_m [5];
  logic [31:0] st_m [5];
  logic        irq_m;

  always #4 clk = ~clk;

  loc_irq_unit u_loc_irq_unit (
    .clk(clk), .rst_n(rst_n), .active_loc(active_loc), .reg_loc(reg_loc),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_vld(evt_vld), .evt_loc(evt_loc),
    .evt_src(evt_src), .irq(irq));

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] src_bits(input logic [3:0] s);
    return {24'b0, s[3], 4'b0, s[2:0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] loc, input logic [1:0] sel, input logic [31:0] exp, input string tag);
    reg_loc = loc; reg_sel = sel; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic step(input logic w, input logic [2:0] loc, input logic [1:0] sel,
                      input logic [3:0] be, input logic [31:0] wd,
                      input logic ev, input logic [2:0] eloc, input logic [3:0] src);
    logic own, drop;
    logic [31:0] set, bm;
    reg_wr = w; reg_loc = loc; reg_sel = sel; reg_be = be; reg_wdata = wd;
    evt_vld = ev; evt_loc = eloc; evt_src = src;
    @(posedge clk);
    own = (active_loc < 3'd5) && (loc == active_loc);
    bm = lanes(be);
    set = 32'h0;
    if (ev && eloc < 3'd5 && en_m[eloc][31]) set = src_bits(src) & en_m[eloc];
    if (w && own && sel == 2'd0) en_m[loc] = (en_m[loc] & ~bm) | (wd & bm & 32'h8000_009F);
    if (w && own && sel == 2'd1) st_m[loc] = st_m[loc] & ~(wd & bm & 32'h87);
    if (ev && eloc < 3'd5) st_m[eloc] = st_m[eloc] | set;
    drop = w && own && sel == 2'd1 && st_m[loc] == 32'h0;
    if (set != 32'h0) irq_m = 1'b1;
    else if (drop) irq_m = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; evt_vld = 1'b0;
  endtask

  task automatic wr(input logic [2:0] loc, input logic [1:0] sel, input logic [3:0] be, input logic [31:0] wd);
    step(1'b1, loc, sel, be, wd, 1'b0, 3'd0, 4'h0);
  endtask

  task automatic ev(input logic [2:0] loc, input logic [3:0] src);
    step(1'b0, 3'd0, 2'd0, 4'h0, 32'h0, 1'b1, loc, src);
  endtask

  task automatic cmp_model(input string tag);
    chk(irq === irq_m, {tag, " irq"}, {31'b0, irq}, {31'b0, irq_m});
    for (int l = 0; l < 5; l++) begin
      rd(3'(l), 2'd0, en_m[l], {tag, " enable"});
      rd(3'(l), 2'd1, st_m[l], {tag, " status"});
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 5; l++) begin en_m[l] = 32'h8; st_m[l] = 32'h0; end
    irq_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R8 fixed reads
    for (int l = 0; l < 5; l++) begin
      rd(3'(l), 2'd0, 32'h8, "R1 enable reset");
      rd(3'(l), 2'd1, 32'h0, "R1 status reset");
    end
    chk(irq === 1'b0, "R1 irq reset", {31'b0, irq}, 32'h0);
    rd(3'd0, 2'd3, 32'h97, "R8 capability");
    rd(3'd0, 2'd2, 32'h5, "R8 vector");
    // R7 no locality active
    wr(3'd0, 2'd0, 4'hF, 32'h8000_0087);
    rd(3'd0, 2'd0, 32'h8, "R7 write with no owner");
    // R2 enable layout
    active_loc = 3'd0;
    wr(3'd0, 2'd0, 4'hF, 32'hFFFF_FFFF);
    rd(3'd0, 2'd0, 32'h8000_009F, "R2 writable mask");
    wr(3'd0, 2'd0, 4'hF, 32'h8000_0087);
    rd(3'd0, 2'd0, 32'h8000_0087, "R2 enable write");
    // R3 R4 latch and raise
    ev(3'd0, 4'b0001);
    rd(3'd0, 2'd1, 32'h1, "R3 data-available latched");
    chk(irq === 1'b1, "R4 irq raised", {31'b0, irq}, 32'h1);
    ev(3'd1, 4'b1111);
    rd(3'd1, 2'd1, 32'h0, "R3 global enable off");
    // R9 invalid locality
    ev(3'd6, 4'b1111);
    rd(3'd0, 2'd1, 32'h1, "R9 invalid target dropped");
    // R3 command-ready maps to bit 7, R6 partial then full clear
    ev(3'd0, 4'b1000);
    rd(3'd0, 2'd1, 32'h81, "R3 command-ready bit 7");
    wr(3'd0, 2'd1, 4'hF, 32'h0000_0001);
    rd(3'd0, 2'd1, 32'h80, "R5 write-one-to-clear");
    chk(irq === 1'b1, "R6 partial clear keeps line", {31'b0, irq}, 32'h1);
    wr(3'd0, 2'd1, 4'hF, 32'h0000_0080);
    chk(irq === 1'b0, "R6 line falls at zero", {31'b0, irq}, 32'h0);
    // R6 fall with another locality pending
    active_loc = 3'd1;
    wr(3'd1, 2'd0, 4'hF, 32'h8000_0004);
    ev(3'd1, 4'b0100);
    ev(3'd0, 4'b0001);
    active_loc = 3'd0;
    wr(3'd0, 2'd1, 4'hF, 32'h1);
    chk(irq === 1'b0, "R6 falls despite other pending", {31'b0, irq}, 32'h0);
    // R7 foreign status write
    wr(3'd1, 2'd1, 4'hF, 32'h4);
    rd(3'd1, 2'd1, 32'h4, "R7 foreign status write ignored");
    // R10 byte lanes
    wr(3'd0, 2'd0, 4'b0001, 32'hFFFF_FF00);
    rd(3'd0, 2'd0, 32'h8000_0000, "R10 low lane only");
    wr(3'd0, 2'd0, 4'b0001, 32'h0000_0001);
    ev(3'd0, 4'b0001);
    wr(3'd0, 2'd1, 4'b1110, 32'hFFFF_FFFF);
    rd(3'd0, 2'd1, 32'h1, "R10 status lane masked");
    // R11 event beats clear
    step(1'b1, 3'd0, 2'd1, 4'hF, 32'h1, 1'b1, 3'd0, 4'b0001);
    rd(3'd0, 2'd1, 32'h1, "R11 event wins over clear");
    chk(irq === 1'b1, "R11 irq stays", {31'b0, irq}, 32'h1);
    // R8 vector write ignored
    wr(3'd0, 2'd2, 4'hF, 32'hFFFF_FFFF);
    rd(3'd0, 2'd2, 32'h5, "R8 vector write ignored");
    cmp_model("R5 directed model");
    // random phase
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'h0) active_loc = 3'($urandom_range(0, 7));
      step(r[4], 3'($urandom_range(0, 6)), r[6:5], r[10:7],
           (r[11] ? 32'h8000_0000 : 32'h0) | ($urandom & 32'h0000_FFFF) | (r[12] ? 32'hFFFF_FFFF : 32'h0),
           r[13], 3'($urandom_range(0, 6)), r[17:14]);
      cmp_model("R3 R6 R7 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule